// File: doc/BRIEF.md
# Supply-loss access guard for battery-backed memory

This block stands between a host's asynchronous-style memory strobes and a memory that is kept alive by a battery. It watches two digital flags from external supply comparators. One flag reports that the supply is above the deselect threshold. The other reports that the supply is above the lower battery-switchover threshold. While the supply is out of tolerance, the block deselects the memory and blocks every write. It turns the data pins to high impedance and ignores chip enable and the other strobes. It also drives the battery-select output from the lower threshold.

When the supply returns, protection is not dropped at once. The block keeps the memory deselected for a programmed number of ticks of a slow timebase. When that interval ends, it releases access and emits a one-cycle pulse that clears the clock control bits.

Host writes are committed at the end of the write strobe. The block emits a single commit strobe carrying the address and data held in the last cycle of the write. If protection trips while a write is open, that write is dropped rather than finished. Because of this, a failing supply can at most leave the addressed location unwritten.

Top module: `pfg_guard`

## Requirements
- R1: With the supply good, the strobes decode as follows. Chip-enable low with write-enable low is a write: the memory is selected and the data pins are not driven, whatever output-enable is. Chip-enable, output-enable and write-enable at low, low, high is a read: the memory is selected and the data pins are driven. Chip-enable low with output-enable high and write-enable high selects the memory without driving the pins. Chip-enable high selects nothing.
- R2: While reset is held, and just after it, the block behaves as if the supply were bad. `protect` and `bat_sel` are 1, `ctl_clr` and `wr_commit` are 0, and the memory is not selected.
- R3: While `protect` is 1, every strobe is ignored. `mem_sel` and `dq_drive` stay 0, and a write strobe never produces a commit.
- R4: Both comparator flags pass through two synchronizer flops. A falling supply-good flag trips protection only after FILT_SAMPLES consecutive low synchronized samples. `protect` rises on exactly the (2+FILT_SAMPLES)-th clock edge after the raw flag falls. A low pulse shorter than FILT_SAMPLES cycles has no effect.
- R5: `bat_sel` equals the inverse of the switchover flag, delayed by two clock edges, in both directions.
- R6: After the synchronized supply-good flag is seen high, `protect` stays 1 until RECOVER_TICKS cycles with `tick` high have been counted. It falls on the edge that counts the last such tick. Ticks seen while the supply is still bad are not counted.
- R7: Any low synchronized supply-good sample during the recovery interval cancels it. After that, a full RECOVER_TICKS ticks are needed again.
- R8: `ctl_clr` is 1 for exactly one cycle, which is the first cycle in which `protect` is 0 after recovery.
- R9: A write ends when write-enable or chip-enable rises. The clock edge after that asserts `wr_commit` for one cycle, with `wr_addr` and `wr_data` equal to the address and data presented in the last cycle of the write.
- R10: A write that is still open or not yet committed when protection trips is discarded. If the write ends in the very cycle whose edge trips protection, the cancel wins and no commit is issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle enable from the slow timebase |
| vgood_raw | input | 1 | Comparator flag: supply above deselect threshold (asynchronous) |
| vbat_raw | input | 1 | Comparator flag: supply above switchover threshold (asynchronous) |
| ce_n | input | 1 | Host chip enable, active low |
| oe_n | input | 1 | Host output enable, active low |
| we_n | input | 1 | Host write enable, active low |
| host_addr | input | ADDR_W | Host address |
| host_wdata | input | DATA_W | Host write data |
| mem_sel | output | 1 | Memory select toward the array |
| dq_drive | output | 1 | Drive enable for the data pins |
| wr_commit | output | 1 | One-cycle write commit strobe |
| wr_addr | output | ADDR_W | Address of the committed write |
| wr_data | output | DATA_W | Data of the committed write |
| bat_sel | output | 1 | Select battery as the memory supply |
| protect | output | 1 | Deselect and write protection in force |
| ctl_clr | output | 1 | One-cycle clear for the clock control bits |

## Verification
The sharp coincidence here is a write ending in the same cycle whose edge trips supply protection. Commit and cancel then compete for one edge. The bench opens a write and drops the raw supply flag. Counting synchronizer and filter stages, it raises write-enable so that the write closes exactly one cycle before protection rises, and it expects no commit in the cycles that follow. A companion run closes the write one cycle earlier. In that case the commit must appear on the edge just before protection, with the right address and data.

// File: rtl/pfg_pkg.sv
package pfg_pkg;

    typedef enum logic [1:0] {
        ACC_IDLE,
        ACC_READ,
        ACC_WRITE,
        ACC_HIZ
    } acc_mode_e;

    typedef enum logic [1:0] {
        PWR_DOWN,
        PWR_RECOVER,
        PWR_UP
    } pwr_state_e;

    typedef struct packed {
        logic sel;
        logic drive;
        logic wr;
    } acc_ctl_t;

    function automatic acc_mode_e decode_strobes(input logic ce_n,
                                                 input logic oe_n,
                                                 input logic we_n);
        if (ce_n)       return ACC_IDLE;
        else if (!we_n) return ACC_WRITE;
        else if (!oe_n) return ACC_READ;
        else            return ACC_HIZ;
    endfunction

    function automatic acc_ctl_t mode_ctl(input acc_mode_e m);
        acc_ctl_t c;
        c = '0;
        case (m)
            ACC_READ:  begin c.sel = 1'b1; c.drive = 1'b1; end
            ACC_WRITE: begin c.sel = 1'b1; c.wr = 1'b1; end
            ACC_HIZ:   c.sel = 1'b1;
            default:   c = '0;
        endcase
        return c;
    endfunction

endpackage

// File: rtl/pfg_sync.sv
module pfg_sync #(
    parameter int  W       = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    for (genvar i = 0; i < W; i++) begin : g_bit
        logic [1:0] stage;
        always_ff @(posedge clk) begin
            if (rst) stage <= {2{RST_VAL}};
            else     stage <= {stage[0], d[i]};
        end
        assign q[i] = stage[1];
    end
endmodule

// File: rtl/pfg_supervisor.sv
module pfg_supervisor
    import pfg_pkg::*;
#(
    parameter int FILT_SAMPLES  = 3,
    parameter int RECOVER_TICKS = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic tick,
    input  logic vgood_s,
    output logic protect,
    output logic trip,
    output logic ctl_clr
);
    localparam int LOW_W = $clog2(FILT_SAMPLES + 1);
    localparam int REC_W = $clog2(RECOVER_TICKS + 1);
    localparam logic [LOW_W-1:0] LOW_LAST = LOW_W'(FILT_SAMPLES - 1);
    localparam logic [REC_W-1:0] REC_LAST = REC_W'(RECOVER_TICKS - 1);

    pwr_state_e       state;
    logic [LOW_W-1:0] low_cnt;
    logic [REC_W-1:0] rec_cnt;
    logic             clr_q;

    // lookahead: the next edge leaves the powered state
    assign trip    = (state == PWR_UP) && !vgood_s && (low_cnt == LOW_LAST);
    assign protect = (state != PWR_UP);
    assign ctl_clr = clr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= PWR_DOWN;
            low_cnt <= '0;
            rec_cnt <= '0;
            clr_q   <= 1'b0;
        end else begin
            clr_q <= 1'b0;
            case (state)
                PWR_DOWN: begin
                    low_cnt <= '0;
                    rec_cnt <= '0;
                    if (vgood_s) state <= PWR_RECOVER;
                end
                PWR_RECOVER: begin
                    if (!vgood_s) begin
                        state   <= PWR_DOWN;
                        rec_cnt <= '0;
                    end else if (tick) begin
                        if (rec_cnt == REC_LAST) begin
                            state <= PWR_UP;
                            clr_q <= 1'b1;
                        end else begin
                            rec_cnt <= rec_cnt + REC_W'(1);
                        end
                    end
                end
                PWR_UP: begin
                    if (trip)          state   <= PWR_DOWN;
                    else if (!vgood_s) low_cnt <= low_cnt + LOW_W'(1);
                    else               low_cnt <= '0;
                end
                default: state <= PWR_DOWN;
            endcase
        end
    end
endmodule

// File: rtl/pfg_access.sv
module pfg_access
    import pfg_pkg::*;
#(
    parameter int ADDR_W = 19,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              protect,
    input  logic              trip,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              mem_sel,
    output logic              dq_drive,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data
);
    acc_ctl_t          ctl;
    logic              wr_pend;
    logic              commit_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] data_q;

    always_comb begin
        ctl = mode_ctl(decode_strobes(ce_n, oe_n, we_n));
        if (protect) ctl = '0;
    end

    assign mem_sel   = ctl.sel;
    assign dq_drive  = ctl.drive;
    assign wr_commit = commit_q;
    assign wr_addr   = addr_q;
    assign wr_data   = data_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_pend  <= 1'b0;
            commit_q <= 1'b0;
            addr_q   <= '0;
            data_q   <= '0;
        end else begin
            // cancel beats commit when both land on one edge
            commit_q <= wr_pend && !ctl.wr && !protect && !trip;
            wr_pend  <= (protect || trip) ? 1'b0 : ctl.wr;
            if (ctl.wr) begin
                addr_q <= host_addr;
                data_q <= host_wdata;
            end
        end
    end
endmodule

// File: rtl/pfg_guard.sv
module pfg_guard
    import pfg_pkg::*;
#(
    parameter int ADDR_W        = 19,
    parameter int DATA_W        = 8,
    parameter int FILT_SAMPLES  = 3,
    parameter int RECOVER_TICKS = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              tick,
    input  logic              vgood_raw,
    input  logic              vbat_raw,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              mem_sel,
    output logic              dq_drive,
    output logic              wr_commit,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              bat_sel,
    output logic              protect,
    output logic              ctl_clr
);
    logic vgood_s, vbat_s, trip;

    pfg_sync #(.W(2), .RST_VAL(1'b0)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({vbat_raw, vgood_raw}),
        .q   ({vbat_s, vgood_s})
    );

    assign bat_sel = !vbat_s;

    pfg_supervisor #(
        .FILT_SAMPLES (FILT_SAMPLES),
        .RECOVER_TICKS(RECOVER_TICKS)
    ) u_sup (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .vgood_s (vgood_s),
        .protect (protect),
        .trip    (trip),
        .ctl_clr (ctl_clr)
    );

    pfg_access #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_acc (
        .clk        (clk),
        .rst        (rst),
        .protect    (protect),
        .trip       (trip),
        .ce_n       (ce_n),
        .oe_n       (oe_n),
        .we_n       (we_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .mem_sel    (mem_sel),
        .dq_drive   (dq_drive),
        .wr_commit  (wr_commit),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data)
    );
endmodule

// File: rtl/pfg_guard_checker.sv
module pfg_guard_checker (
    input logic clk,
    input logic rst,
    input logic protect,
    input logic mem_sel,
    input logic dq_drive,
    input logic wr_commit,
    input logic ctl_clr
);
    assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
        protect |-> (!mem_sel && !dq_drive));

    assert_commit_unprotected_R10: assert property (@(posedge clk) disable iff (rst)
        wr_commit |-> !$past(protect));

    assert_commit_single_R9: assert property (@(posedge clk) disable iff (rst)
        wr_commit |=> !wr_commit);

    assert_release_pulse_R6: assert property (@(posedge clk) disable iff (rst)
        $fell(protect) |-> ctl_clr);

    assert_clr_unprotected_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_clr |-> !protect);

    assert_clr_single_R8: assert property (@(posedge clk) disable iff (rst)
        ctl_clr |=> !ctl_clr);
endmodule

bind pfg_guard pfg_guard_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .protect   (protect),
    .mem_sel   (mem_sel),
    .dq_drive  (dq_drive),
    .wr_commit (wr_commit),
    .ctl_clr   (ctl_clr)
);

// File: tb/pfg_guard_bench.sv
`timescale 1ns/1ps
module pfg_guard_bench;
    localparam int AW = 19;
    localparam int DW = 8;
    localparam int FS = 3;
    localparam int RT = 5;

    logic clk = 1'b0;
    logic rst, tick, vgood_raw, vbat_raw, ce_n, oe_n, we_n;
    logic [AW-1:0] host_addr;
    logic [DW-1:0] host_wdata;
    logic mem_sel, dq_drive, wr_commit, bat_sel, protect, ctl_clr;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    int n_cmp = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    pfg_guard #(.ADDR_W(AW), .DATA_W(DW), .FILT_SAMPLES(FS), .RECOVER_TICKS(RT)) u_pfg_guard (
        .clk(clk), .rst(rst), .tick(tick), .vgood_raw(vgood_raw), .vbat_raw(vbat_raw),
        .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n), .host_addr(host_addr), .host_wdata(host_wdata),
        .mem_sel(mem_sel), .dq_drive(dq_drive), .wr_commit(wr_commit), .wr_addr(wr_addr),
        .wr_data(wr_data), .bat_sel(bat_sel), .protect(protect), .ctl_clr(ctl_clr)
    );

    // {ce_n, oe_n, we_n, expected mem_sel, expected dq_drive}
    localparam logic [4:0] VEC [5] = '{
        5'b10100, 5'b00111, 5'b01110, 5'b00010, 5'b01010
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic pulse_tick();
        tick = 1'b1;
        step(1);
        tick = 1'b0;
    endtask

    task automatic no_commit(input string req, input int n);
        bit seen = 1'b0;
        for (int i = 0; i < n; i++) begin
            step(1);
            if (wr_commit) seen = 1'b1;
        end
        chk(req, {31'd0, seen}, 32'd0);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; tick = 1'b0; vgood_raw = 1'b0; vbat_raw = 1'b0;
        ce_n = 1'b0; oe_n = 1'b0; we_n = 1'b1; host_addr = '0; host_wdata = '0;
        step(3);
        chk("R2 protect", {31'd0, protect}, 1);
        chk("R2 bat_sel", {31'd0, bat_sel}, 1);
        chk("R2 ctl_clr", {31'd0, ctl_clr}, 0);
        chk("R2 wr_commit", {31'd0, wr_commit}, 0);
        chk("R2 mem_sel", {31'd0, mem_sel}, 0);
        rst = 1'b0;
        step(1);
        chk("R3 read ignored while protected", {30'd0, mem_sel, dq_drive}, 0);
        ce_n = 1'b1; oe_n = 1'b1;

        // ticks while supply is bad must not count (R6)
        for (int i = 0; i < RT; i++) pulse_tick();

        vgood_raw = 1'b1; vbat_raw = 1'b1;
        step(1);
        chk("R5 bat_sel after one edge", {31'd0, bat_sel}, 1);
        step(1);
        chk("R5 bat_sel after two edges", {31'd0, bat_sel}, 0);
        step(2);
        for (int i = 0; i < RT - 1; i++) pulse_tick();
        chk("R6 held before last tick", {31'd0, protect}, 1);
        pulse_tick();
        chk("R6 released on last tick", {31'd0, protect}, 0);
        chk("R8 clear pulse high", {31'd0, ctl_clr}, 1);
        step(1);
        chk("R8 clear pulse one cycle", {31'd0, ctl_clr}, 0);

        // R1 strobe decoding table
        for (int i = 0; i < 5; i++) begin
            {ce_n, oe_n, we_n} = VEC[i][4:2];
            #1;
            chk($sformatf("R1 vector %0d", i), {30'd0, mem_sel, dq_drive}, {30'd0, VEC[i][1:0]});
            step(1);
        end
        ce_n = 1'b1; oe_n = 1'b1; we_n = 1'b1;
        step(3);

        // R9 write committed at its end with last-cycle address/data
        host_addr = 19'h5A5A5; host_wdata = 8'h11; ce_n = 1'b0; we_n = 1'b0;
        step(1);
        host_wdata = 8'h3C;
        step(1);
        we_n = 1'b1; ce_n = 1'b1;
        step(1);
        chk("R9 commit strobe", {31'd0, wr_commit}, 1);
        chk("R9 commit addr", {13'd0, wr_addr}, 32'h5A5A5);
        chk("R9 commit data", {24'd0, wr_data}, 32'h3C);
        step(1);
        chk("R9 commit one cycle", {31'd0, wr_commit}, 0);

        // R4 short dip is filtered
        begin
            bit tripped = 1'b0;
            vgood_raw = 1'b0;
            step(FS - 1);
            vgood_raw = 1'b1;
            for (int i = 0; i < 8; i++) begin
                step(1);
                if (protect) tripped = 1'b1;
            end
            chk("R4 short dip ignored", {31'd0, tripped}, 0);
            ce_n = 1'b0; oe_n = 1'b0;
            #1;
            chk("R4 read still served after dip", {31'd0, dq_drive}, 1);
            ce_n = 1'b1; oe_n = 1'b1;
            step(1);
        end

        // R10 write ends in the cycle whose edge trips protection
        host_addr = 19'h00777; host_wdata = 8'hE1; ce_n = 1'b0; we_n = 1'b0;
        step(1);
        vgood_raw = 1'b0;
        step(2 + FS - 1);
        chk("R4 not yet tripped", {31'd0, protect}, 0);
        we_n = 1'b1; ce_n = 1'b1;
        step(1);
        chk("R4 tripped on expected edge", {31'd0, protect}, 1);
        no_commit("R10 tie cancels write", 4);

        // R3 strobes ignored while protected
        ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        #1;
        chk("R3 write strobe deselected", {30'd0, mem_sel, dq_drive}, 0);
        step(3);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        no_commit("R3 protected write not committed", 3);

        // R5 falling switchover flag
        vbat_raw = 1'b0;
        step(1);
        chk("R5 bat_sel latency one edge", {31'd0, bat_sel}, 0);
        step(1);
        chk("R5 bat_sel asserted", {31'd0, bat_sel}, 1);

        // R7 dip during recovery restarts the interval
        vbat_raw = 1'b1; vgood_raw = 1'b1;
        step(4);
        pulse_tick(); pulse_tick();
        vgood_raw = 1'b0;
        step(1);
        vgood_raw = 1'b1;
        step(5);
        for (int i = 0; i < RT - 1; i++) pulse_tick();
        chk("R7 interval restarted", {31'd0, protect}, 1);
        pulse_tick();
        chk("R7 release after full interval", {31'd0, protect}, 0);
        chk("R8 pulse after restart", {31'd0, ctl_clr}, 1);
        step(2);

        // R10 companion: write ends one cycle before trip, commit survives
        host_addr = 19'h12345; host_wdata = 8'h9D; ce_n = 1'b0; we_n = 1'b0;
        step(1);
        vgood_raw = 1'b0;
        step(2 + FS - 2);
        we_n = 1'b1; ce_n = 1'b1;
        step(1);
        chk("R10 earlier end commits", {31'd0, wr_commit}, 1);
        chk("R10 earlier end data", {24'd0, wr_data}, 32'h9D);
        step(1);
        chk("R4 protect after earlier end", {31'd0, protect}, 1);

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule